// File: doc/BRIEF.md
# Instruction Fetch and Address Router

This block is the front end of a single-cycle 32-bit integer core. It owns the program counter and the instruction register. Each cycle it presents the program counter as the fetch address and decodes the top address byte to enable exactly one of two instruction memories: a boot ROM or a RAM. On the clock edge it latches the returned 32-bit word into the instruction register, together with the address that word came from, so the decoder can work on it. A fetch from an unmapped region or from a misaligned address raises a fault flag and leaves the instruction register as it was.

The next program counter is picked in the same cycle from four sources, with no flush and no prediction. In order of precedence these are a trap vector, a return-from-trap address, a taken jump or branch target, and the sequential address four bytes on. After a synchronous active-low reset, fetch starts at a fixed boot address.

Top module: `ifetch_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next `fetch_addr` is 0x80000000, and `ir`, `ir_pc` and `ir_valid` are all zero.
- R2: When none of `trap_req`, `mret_req` and `jump_taken` is high, `fetch_addr` increases by 4 at each clock edge.
- R3: When `jump_taken` is high and neither `trap_req` nor `mret_req` is high, `fetch_addr` equals `jump_target` after the next clock edge.
- R4: When `trap_req` is high, `fetch_addr` equals `trap_target` after the next clock edge, whatever `mret_req` and `jump_taken` are.
- R5: When `mret_req` is high and `trap_req` is low, `fetch_addr` equals `mret_target` after the next clock edge, even if `jump_taken` is high.
- R6: In the same cycle, an aligned `fetch_addr` whose bits [31:24] equal 0x80 drives `boot_rd_en` high and `ram_rd_en` and `fetch_fault` low.
- R7: In the same cycle, an aligned `fetch_addr` whose bits [31:24] equal 0x02 drives `ram_rd_en` high and `boot_rd_en` and `fetch_fault` low.
- R8: In the same cycle, a `fetch_addr` whose bits [1:0] are not zero, or whose bits [31:24] are neither 0x80 nor 0x02, drives `fetch_fault` high and both read enables low. The program counter still follows R2 to R5 in that cycle.
- R9: At a clock edge where `fetch_fault` is high, `ir`, `ir_pc` and `ir_valid` keep their values.
- R10: At a clock edge where `fetch_fault` is low, `ir` takes the enabled memory's read data, `ir_pc` takes `fetch_addr`, and `ir_valid` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jump_taken | input | 1 | The current instruction is a taken jump or branch |
| jump_target | input | 32 | Target of the jump or branch |
| mret_req | input | 1 | Return from the trap handler |
| mret_target | input | 32 | Saved return address |
| trap_req | input | 1 | An exception or interrupt is being taken |
| trap_target | input | 32 | Trap handler address |
| fetch_addr | output | 32 | Current program counter, used as the fetch address |
| boot_rd_en | output | 1 | Read enable for the boot ROM |
| ram_rd_en | output | 1 | Read enable for the instruction RAM |
| boot_rdata | input | 32 | Word read from the boot ROM, combinational from `fetch_addr` |
| ram_rdata | input | 32 | Word read from the RAM, combinational from `fetch_addr` |
| fetch_fault | output | 1 | The fetch address is unmapped or misaligned |
| ir | output | 32 | Instruction register |
| ir_pc | output | 32 | Address of the instruction held in `ir` |
| ir_valid | output | 1 | `ir` holds a fetched word |

## Verification
The read enables and the fault flag are combinational from the program counter, so they are due in the same cycle that `fetch_addr` changes. The next program counter and the instruction register contents are due one clock edge after the redirect inputs and the read data that produced them. The bench changes inputs on the falling edge and checks the select outputs there before the rising edge. It then checks `fetch_addr`, `ir`, `ir_pc` and `ir_valid` on the following falling edge, against a model that it advances once per edge from the requirements.

// File: rtl/ifr_pkg.sv
// Package: shared types for the instruction fetch and address router.
// Assumes: nothing beyond IEEE 1800-2017.
package ifr_pkg;

    // Source picked for the next program counter, highest precedence last.
    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_JUMP = 2'd1,
        SRC_MRET = 2'd2,
        SRC_TRAP = 2'd3
    } pc_src_e;

endpackage

// File: rtl/ifr_pc_unit.sv
// Module: ifr_pc_unit
// Holds the program counter and picks the next one each cycle from the
// sequential step, a jump target, a trap-return address or a trap vector.
// Assumes: redirect inputs belong to the instruction fetched this cycle and
// are valid before the rising edge; targets are not realigned here.
module ifr_pc_unit
    import ifr_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              STEP      = 4,
    parameter logic [XLEN-1:0] BOOT_ADDR = 32'h8000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            jump_taken,
    input  logic [XLEN-1:0] jump_target,
    input  logic            mret_req,
    input  logic [XLEN-1:0] mret_target,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_target,
    output logic [XLEN-1:0] pc
);

    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    pc_src_e         src;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;

    // Pick the redirect source by fixed precedence: trap, return, jump, step.
    always_comb begin
        if (trap_req)        src = SRC_TRAP;
        else if (mret_req)   src = SRC_MRET;
        else if (jump_taken) src = SRC_JUMP;
        else                 src = SRC_SEQ;
    end

    // Turn the chosen source into the next address.
    always_comb begin
        unique case (src)
            SRC_TRAP: pc_next = trap_target;
            SRC_MRET: pc_next = mret_target;
            SRC_JUMP: pc_next = jump_target;
            default:  pc_next = pc_q + STEP_V;
        endcase
    end

    // Program counter register, loaded with the boot address in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= BOOT_ADDR;
        else        pc_q <= pc_next;
    end

    assign pc = pc_q;

    // R2: with no redirect the counter steps by one instruction.
    a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !mret_req && !jump_taken) |=> (pc == $past(pc) + STEP_V));

    // R3: a lone jump lands on its target.
    a_r3_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_taken && !trap_req && !mret_req) |=> (pc == $past(jump_target)));

    // R4: a trap wins over every other source.
    a_r4_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (pc == $past(trap_target)));

    // R5: a trap return wins over a jump.
    a_r5_mret_over_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_req && !trap_req) |=> (pc == $past(mret_target)));

endmodule

// File: rtl/ifr_addr_decode.sv
// Module: ifr_addr_decode
// Decodes the top address byte of the fetch address into one read enable per
// instruction memory, or into a fault when the address is unmapped or not on
// an instruction boundary.
// Assumes: exactly two regions; region selectors differ from each other.
module ifr_addr_decode #(
    parameter int                XLEN        = 32,
    parameter int                INSTR_BYTES = 4,
    parameter int                SEL_W       = 8,
    parameter logic [SEL_W-1:0]  BOOT_SEL    = 8'h80,
    parameter logic [SEL_W-1:0]  RAM_SEL     = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] addr,
    output logic            boot_en,
    output logic            ram_en,
    output logic            fault
);

    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);
    localparam int NPORT      = 2;

    logic [NPORT-1:0] hit;
    logic             aligned;
    logic             unused_mid_bits;

    // An instruction must start on a whole-word boundary.
    assign aligned = (addr[ALIGN_BITS-1:0] == '0);

    // Middle address bits select a word inside a region; not decoded here.
    assign unused_mid_bits = ^addr[XLEN-SEL_W-1:ALIGN_BITS];

    // One comparator per memory region: index 0 boot ROM, index 1 RAM.
    for (genvar g = 0; g < NPORT; g++) begin : g_region
        localparam logic [SEL_W-1:0] SEL = (g == 0) ? BOOT_SEL : RAM_SEL;
        assign hit[g] = aligned && (addr[XLEN-1 -: SEL_W] == SEL);
    end

    assign boot_en = hit[0];
    assign ram_en  = hit[1];
    assign fault   = ~|hit;

    // R8: exactly one of the two enables and the fault flag is active.
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({boot_en, ram_en, fault}) == 1);

    // R8: a misaligned address never enables a memory.
    a_r8_misaligned_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ALIGN_BITS-1:0] != '0) |-> !(boot_en || ram_en));

endmodule

// File: rtl/ifr_instr_reg.sv
// Module: ifr_instr_reg
// Instruction register: latches the fetched word and the address it came
// from, and marks the register valid once a word has been captured.
// Assumes: capture is low for any fetch that raised a fault.
module ifr_instr_reg #(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [ILEN-1:0] word,
    input  logic [XLEN-1:0] word_pc,
    output logic [ILEN-1:0] ir,
    output logic [XLEN-1:0] ir_pc,
    output logic            ir_valid
);

    // Capture word and address on a clean fetch, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir       <= '0;
            ir_pc    <= '0;
            ir_valid <= 1'b0;
        end else if (capture) begin
            ir       <= word;
            ir_pc    <= word_pc;
            ir_valid <= 1'b1;
        end
    end

    // R9: a faulting fetch leaves the register untouched.
    a_r9_hold_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(ir) && $stable(ir_pc) && $stable(ir_valid)));

    // R10: a clean fetch loads the word and its address.
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ir_valid && ir == $past(word) && ir_pc == $past(word_pc)));

endmodule

// File: rtl/ifetch_router.sv
// Module: ifetch_router
// Front end of a single-cycle core: program counter, next-address choice,
// routing of the fetch to the boot ROM or the RAM, fault detection for
// unmapped or misaligned fetches, and the instruction register.
// Assumes: both memories return read data combinationally from fetch_addr;
// the redirect inputs are settled before each rising edge.
module ifetch_router #(
    parameter int                XLEN        = 32,
    parameter int                ILEN        = 32,
    parameter int                INSTR_BYTES = 4,
    parameter int                SEL_W       = 8,
    parameter logic [XLEN-1:0]   BOOT_ADDR   = 32'h8000_0000,
    parameter logic [SEL_W-1:0]  BOOT_SEL    = 8'h80,
    parameter logic [SEL_W-1:0]  RAM_SEL     = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            jump_taken,
    input  logic [XLEN-1:0] jump_target,
    input  logic            mret_req,
    input  logic [XLEN-1:0] mret_target,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_target,
    output logic [XLEN-1:0] fetch_addr,
    output logic            boot_rd_en,
    output logic            ram_rd_en,
    input  logic [ILEN-1:0] boot_rdata,
    input  logic [ILEN-1:0] ram_rdata,
    output logic            fetch_fault,
    output logic [ILEN-1:0] ir,
    output logic [XLEN-1:0] ir_pc,
    output logic            ir_valid
);

    logic [XLEN-1:0] pc;
    logic [ILEN-1:0] fetched_word;

    ifr_pc_unit #(
        .XLEN      (XLEN),
        .STEP      (INSTR_BYTES),
        .BOOT_ADDR (BOOT_ADDR)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .jump_taken  (jump_taken),
        .jump_target (jump_target),
        .mret_req    (mret_req),
        .mret_target (mret_target),
        .trap_req    (trap_req),
        .trap_target (trap_target),
        .pc          (pc)
    );

    ifr_addr_decode #(
        .XLEN        (XLEN),
        .INSTR_BYTES (INSTR_BYTES),
        .SEL_W       (SEL_W),
        .BOOT_SEL    (BOOT_SEL),
        .RAM_SEL     (RAM_SEL)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (pc),
        .boot_en (boot_rd_en),
        .ram_en  (ram_rd_en),
        .fault   (fetch_fault)
    );

    // Steer the enabled memory's data toward the instruction register.
    always_comb begin
        if (boot_rd_en) fetched_word = boot_rdata;
        else            fetched_word = ram_rdata;
    end

    ifr_instr_reg #(
        .XLEN (XLEN),
        .ILEN (ILEN)
    ) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (!fetch_fault),
        .word     (fetched_word),
        .word_pc  (pc),
        .ir       (ir),
        .ir_pc    (ir_pc),
        .ir_valid (ir_valid)
    );

    assign fetch_addr = pc;

endmodule

// File: tb/ifetch_router_test.sv
`timescale 1ns/1ps
// Directed bench for ifetch_router: one task per scenario, each checking
// its own results against a model advanced once per clock edge.
module ifetch_router_test;

    localparam logic [31:0] BOOT  = 32'h8000_0000;
    localparam logic [31:0] BMASK = 32'hA5A5_0F0F;
    localparam logic [31:0] RMASK = 32'h3C3C_5555;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jump_taken = 1'b0;
    logic [31:0] jump_target = '0;
    logic        mret_req = 1'b0;
    logic [31:0] mret_target = '0;
    logic        trap_req = 1'b0;
    logic [31:0] trap_target = '0;
    logic [31:0] fetch_addr;
    logic        boot_rd_en;
    logic        ram_rd_en;
    logic [31:0] boot_rdata;
    logic [31:0] ram_rdata;
    logic        fetch_fault;
    logic [31:0] ir;
    logic [31:0] ir_pc;
    logic        ir_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_pc = BOOT;
    logic [31:0] exp_ir = '0;
    logic [31:0] exp_irpc = '0;
    logic        exp_v = 1'b0;

    always #2.5 clk = ~clk;

    // Memory models: each returns a word derived from the fetch address.
    assign boot_rdata = fetch_addr ^ BMASK;
    assign ram_rdata  = fetch_addr ^ RMASK;

    ifetch_router uut (
        .clk(clk), .rst_n(rst_n),
        .jump_taken(jump_taken), .jump_target(jump_target),
        .mret_req(mret_req), .mret_target(mret_target),
        .trap_req(trap_req), .trap_target(trap_target),
        .fetch_addr(fetch_addr), .boot_rd_en(boot_rd_en), .ram_rd_en(ram_rd_en),
        .boot_rdata(boot_rdata), .ram_rdata(ram_rdata),
        .fetch_fault(fetch_fault), .ir(ir), .ir_pc(ir_pc), .ir_valid(ir_valid)
    );

    // Region of an address: 0 boot, 1 RAM, 2 fault.
    function automatic int region(input logic [31:0] a);
        if (a[1:0] != 2'b00)     return 2;
        if (a[31:24] == 8'h80)   return 0;
        if (a[31:24] == 8'h02)   return 1;
        return 2;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Advance the model over one rising edge, then wait to the falling edge.
    task automatic tick();
        if (!rst_n) begin
            exp_pc = BOOT; exp_ir = '0; exp_irpc = '0; exp_v = 1'b0;
        end else begin
            if (region(exp_pc) != 2) begin
                exp_ir   = exp_pc ^ ((region(exp_pc) == 0) ? BMASK : RMASK);
                exp_irpc = exp_pc;
                exp_v    = 1'b1;
            end
            if (trap_req)        exp_pc = trap_target;
            else if (mret_req)   exp_pc = mret_target;
            else if (jump_taken) exp_pc = jump_target;
            else                 exp_pc = exp_pc + 32'd4;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_regs(input string tag);
        chk({tag, " fetch_addr"}, fetch_addr, exp_pc);
        chk({tag, " ir"}, ir, exp_ir);
        chk({tag, " ir_pc"}, ir_pc, exp_irpc);
        chk({tag, " ir_valid"}, {31'd0, ir_valid}, {31'd0, exp_v});
    endtask

    task automatic chk_sel(input string tag);
        int r;
        r = region(exp_pc);
        chk({tag, " boot_rd_en"}, {31'd0, boot_rd_en}, {31'd0, r == 0});
        chk({tag, " ram_rd_en"}, {31'd0, ram_rd_en}, {31'd0, r == 1});
        chk({tag, " fetch_fault"}, {31'd0, fetch_fault}, {31'd0, r == 2});
    endtask

    task automatic clear_redirects();
        jump_taken = 1'b0; mret_req = 1'b0; trap_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        chk_regs("R1 reset");
        chk_sel("R6 boot after reset");
        rst_n = 1'b1;
    endtask

    task automatic t_sequential();
        for (int i = 0; i < 4; i++) begin
            chk_sel("R6 boot sequential");
            tick();
            chk_regs("R2 R10 sequential");
        end
    endtask

    task automatic t_jump_to_ram();
        jump_taken = 1'b1; jump_target = 32'h0200_0100;
        tick();
        clear_redirects();
        chk_regs("R3 jump");
        chk_sel("R7 ram select");
        tick();
        chk_regs("R10 ram capture");
        chk_sel("R7 ram sequential");
    endtask

    task automatic t_priority();
        trap_req = 1'b1; trap_target = 32'h8000_0200;
        mret_req = 1'b1; mret_target = 32'h0200_0040;
        jump_taken = 1'b1; jump_target = 32'h0200_0800;
        tick();
        chk_regs("R4 trap over mret and jump");
        trap_req = 1'b0;
        tick();
        chk_regs("R5 mret over jump");
        chk_sel("R7 ram after mret");
        clear_redirects();
        tick();
        chk_regs("R2 after mret");
    endtask

    task automatic t_fault_region();
        jump_taken = 1'b1; jump_target = 32'h4000_0000;
        tick();
        clear_redirects();
        chk_sel("R8 unmapped byte");
        tick();
        chk_regs("R9 hold on unmapped, R8 pc steps");
        trap_req = 1'b1; trap_target = 32'h8000_0010;
        tick();
        clear_redirects();
        chk_regs("R8 trap out of fault");
        chk_sel("R6 boot after recovery");
        tick();
        chk_regs("R10 capture after recovery");
    endtask

    task automatic t_fault_misaligned();
        jump_taken = 1'b1; jump_target = 32'h0200_0002;
        tick();
        chk_sel("R8 misaligned");
        jump_target = 32'h0200_0008;
        tick();
        clear_redirects();
        chk_regs("R9 hold on misaligned, R3 jump from fault");
        chk_sel("R7 ram after misaligned");
        tick();
        chk_regs("R10 capture after misaligned");
    endtask

    task automatic t_reset_midrun();
        rst_n = 1'b0;
        tick();
        chk_regs("R1 reset mid-run");
        rst_n = 1'b1;
        tick();
        chk_regs("R10 first fetch after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_jump_to_ram();
        t_priority();
        t_fault_region();
        t_fault_misaligned();
        t_reset_midrun();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule